// File: doc/BRIEF.md
# Transition-Triggered ROM Read Controller

This block is a clocked model of a byte-wide read-only memory whose reads are launched from inside the block rather than by a strobe. Every clock edge samples the address and the chip-select input. When a sample differs from the one taken on the edge before, a new access begins. No other event starts an access. After reset nothing has been read, so the data-valid flag stays low until the first such change.

Array contents come from a fixed arithmetic function of the address, so no memory image is loaded. All delays are whole clock cycles, derived from nanosecond parameters and the clock period:

- address and select access,
- output-enable access,
- hold of the old word after a new access begins,
- the disable window after the outputs are switched off.

The polarity of chip select and of output enable is each a build-time parameter. Chip select and output enable are plain level inputs. The outputs are plain held levels with no back-pressure. A consumer takes `data_o` in any cycle where `data_valid_o` is high. Data is driven only while `drive_en_o` is high; otherwise `data_o` reads zero.

Top module: `atd_rom`

## Requirements
- R1: The word at address a equals ((a*29 + (a>>8) + (a>>16)*90) XOR 165) mod 256.
- R2: After reset, data_valid_o stays 0 until the address or chip select changes, even with both enables active.
- R3: An address change sampled on edge 1 gives data_valid_o = 1 with the new word after edge ACC+1, where ACC = ceil(access_ns/clk_ns), and 0 after edge ACC.
- R4: A chip-select change alone, with the address unchanged, starts a full access. When select becomes active, data_valid_o rises after edge ACC+1.
- R5: Output-enable changes never start an access. With the word already read, re-enabling output gives data_valid_o = 1 after edge OEA+1 (OEA = ceil(oe_ns/clk_ns)) and 0 after edge OEA.
- R6: After a new access starts, the previous word stays valid on the outputs through edge HOLD. data_valid_o is 0 after edge HOLD+1.
- R7: A transition during an access restarts it. Valid rises ACC+1 edges after the last change, carrying the last address's word.
- R8: With chip select inactive, standby_o = 1 from edge 1, data_valid_o = 0, and the drive stays off whatever output enable does.
- R9: With chip select active and output enable inactive, standby_o = 0 and, once the disable window ends, drive_en_o = 0.
- R10: Data is driven only after both enables are active. When drive_en_o = 0, data_o reads 0. data_valid_o = 1 implies drive_en_o = 1.
- R11: When either enable goes inactive, data_valid_o drops after edge 1. drive_en_o holds the word through edge DIS and falls after edge DIS+1 (DIS = ceil(disable_ns/clk_ns)).
- R12: With the default polarity parameters both enables are active low. Setting each parameter to 1 makes that enable active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| ce_i | input | 1 | Chip select, polarity by CE_ACTIVE_HIGH |
| oe_i | input | 1 | Output enable, polarity by OE_ACTIVE_HIGH |
| data_o | output | DATA_W | Data word, zero when not driven |
| data_valid_o | output | 1 | Word on data_o is complete and enabled |
| drive_en_o | output | 1 | Outputs driven (stands in for tri-state) |
| standby_o | output | 1 | Chip select inactive |

## Verification
The assertions check a set of invariants on every cycle:

- valid never appears before the first transition;
- valid rises only as an access counter expires;
- any transition reloads the access counter;
- the access counter stays idle without a transition;
- valid implies drive;
- standby excludes valid;
- the drive is off once both enables are low and the disable window is over.

Some behaviour only the bench scenarios can show: the exact edge on which valid rises and falls, and the words read across a sweep of walking-one and scattered addresses. The same holds for the behaviour of a chip-select toggle against an output-enable toggle, an access restarted mid-flight, and the active-high build.

// File: rtl/atd_rom_pkg.sv
package atd_rom_pkg;

  // Round a nanosecond delay up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  // Array contents as an arithmetic mix of the address bits.
  function automatic logic [31:0] rom_mix(input logic [31:0] a);
    logic [31:0] v;
    v = (a * 32'd29) + (a >> 8) + ((a >> 16) * 32'd90);
    return v ^ 32'h0000_00A5;
  endfunction

endpackage

// File: rtl/atd_rom_edge.sv
module atd_rom_edge #(
  parameter int ADDR_W  = 17,
  parameter bit CE_HIGH = 1'b0,
  parameter bit OE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_pin_i,
  input  logic              oe_pin_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ce_q,
  output logic              oe_q,
  output logic              trig_q
);
  logic ce_act, oe_act, primed;

  // Polarity normalisation chosen at build time.
  generate
    if (CE_HIGH) begin : g_ce_hi
      assign ce_act = ce_pin_i;
    end else begin : g_ce_lo
      assign ce_act = ~ce_pin_i;
    end
    if (OE_HIGH) begin : g_oe_hi
      assign oe_act = oe_pin_i;
    end else begin : g_oe_lo
      assign oe_act = ~oe_pin_i;
    end
  endgenerate

  // First sample after reset only primes the history; no access starts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce_q   <= 1'b0;
      oe_q   <= 1'b0;
      primed <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      addr_q <= addr_i;
      ce_q   <= ce_act;
      oe_q   <= oe_act;
      primed <= 1'b1;
      trig_q <= primed && ((addr_i != addr_q) || (ce_act != ce_q));
    end
  end

endmodule

// File: rtl/atd_rom_seq.sv
module atd_rom_seq #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int ACC_CYC  = 10,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              word_ok_o
);
  localparam int CW = $clog2(ACC_CYC + 1);

  logic [CW-1:0]     acc_cnt, hold_cnt;
  logic [ADDR_W-1:0] lat_addr;
  logic [31:0]       mix;
  logic [DATA_W-1:0] word;

  always_comb begin
    mix  = atd_rom_pkg::rom_mix(32'(lat_addr));
    word = mix[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt   <= '0;
      hold_cnt  <= '0;
      lat_addr  <= '0;
      data_o    <= '0;
      word_ok_o <= 1'b0;
    end else if (trig_i) begin
      lat_addr <= addr_i;
      acc_cnt  <= CW'(ACC_CYC - 1);
      hold_cnt <= CW'(HOLD_CYC - 1);
      if (HOLD_CYC == 1) word_ok_o <= 1'b0;
    end else begin
      if (hold_cnt != '0) begin
        if (hold_cnt == CW'(1)) word_ok_o <= 1'b0;
        hold_cnt <= hold_cnt - 1'b1;
      end
      if (acc_cnt != '0) begin
        if (acc_cnt == CW'(1)) begin
          data_o    <= word;
          word_ok_o <= 1'b1;
        end
        acc_cnt <= acc_cnt - 1'b1;
      end
    end
  end

  // R3: a word becomes ready only as the access count expires
  p_ready_at_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ok_o) |-> $past(acc_cnt) == CW'(1));

  // R7: every detected transition reloads the access count
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> acc_cnt == CW'(ACC_CYC - 1));

  // R5: no access starts without a transition
  p_idle_no_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt == '0 && !trig_i) |=> acc_cnt == '0);

endmodule

// File: rtl/atd_rom_gate.sv
module atd_rom_gate #(
  parameter int DATA_W  = 8,
  parameter int OEA_CYC = 4,
  parameter int DIS_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_q,
  input  logic              oe_q,
  input  logic              word_ok_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              drive_o,
  output logic              standby_o
);
  localparam int OW = $clog2(OEA_CYC + 1);
  localparam int DW = $clog2(DIS_CYC + 1);

  logic          both, both_d, oe_ok;
  logic [OW-1:0] oe_cnt;
  logic [DW-1:0] dis_cnt;

  assign both = ce_q & oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_d  <= 1'b0;
      oe_cnt  <= '0;
      oe_ok   <= 1'b0;
      dis_cnt <= '0;
    end else begin
      both_d <= both;
      if (both && !both_d) begin
        oe_cnt  <= OW'(OEA_CYC - 1);
        oe_ok   <= (OEA_CYC == 1);
        dis_cnt <= '0;
      end else if (!both && both_d) begin
        oe_cnt  <= '0;
        oe_ok   <= 1'b0;
        dis_cnt <= oe_ok ? DW'(DIS_CYC - 1) : '0;
      end else begin
        if (oe_cnt != '0) begin
          if (oe_cnt == OW'(1)) oe_ok <= 1'b1;
          oe_cnt <= oe_cnt - 1'b1;
        end
        if (dis_cnt != '0) dis_cnt <= dis_cnt - 1'b1;
      end
    end
  end

  assign drive_o   = oe_ok | (dis_cnt != '0);
  assign data_o    = drive_o ? word_i : '0;
  assign valid_o   = word_ok_i & oe_ok & both;
  assign standby_o = ~ce_q;

  // R10: a valid word is always being driven
  p_valid_drives_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> drive_o);

  // R11: drive is off once the disable window has ended
  p_window_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!both && !both_d && dis_cnt == '0) |-> !drive_o);

  // R8: standby never coexists with valid data
  p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !valid_o);

endmodule

// File: rtl/atd_rom.sv
module atd_rom #(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter bit CE_ACTIVE_HIGH = 1'b0,
  parameter bit OE_ACTIVE_HIGH = 1'b0,
  parameter int CLK_NS         = 10,
  parameter int ACC_NS         = 100,
  parameter int OE_NS          = 40,
  parameter int HOLD_NS        = 20,
  parameter int DIS_NS         = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              drive_en_o,
  output logic              standby_o
);
  localparam int ACC_CYC  = atd_rom_pkg::ns_to_cyc(ACC_NS, CLK_NS);
  localparam int OEA_CYC  = atd_rom_pkg::ns_to_cyc(OE_NS, CLK_NS);
  localparam int HOLD_CYC = atd_rom_pkg::ns_to_cyc(HOLD_NS, CLK_NS);
  localparam int DIS_CYC  = atd_rom_pkg::ns_to_cyc(DIS_NS, CLK_NS);

  logic [ADDR_W-1:0] addr_q;
  logic              ce_q, oe_q, trig;
  logic [DATA_W-1:0] word;
  logic              word_ok;

  atd_rom_edge #(.ADDR_W(ADDR_W), .CE_HIGH(CE_ACTIVE_HIGH), .OE_HIGH(OE_ACTIVE_HIGH)) u_edge (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_pin_i(ce_i), .oe_pin_i(oe_i),
    .addr_q(addr_q), .ce_q(ce_q), .oe_q(oe_q), .trig_q(trig)
  );

  atd_rom_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .addr_i(addr_q),
    .data_o(word), .word_ok_o(word_ok)
  );

  atd_rom_gate #(.DATA_W(DATA_W), .OEA_CYC(OEA_CYC), .DIS_CYC(DIS_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .ce_q(ce_q), .oe_q(oe_q), .word_ok_i(word_ok), .word_i(word),
    .data_o(data_o), .valid_o(data_valid_o), .drive_o(drive_en_o), .standby_o(standby_o)
  );

  // Checker state: has any transition been seen since reset.
  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else if (trig) seen_edge <= 1'b1;
  end

  // R2: no valid word before the first transition
  p_powerup_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_edge |-> !data_valid_o);

endmodule

// File: tb/atd_rom_tb.sv
module atd_rom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACC  = 10;
  localparam int OEA  = 4;
  localparam int HOLD = 2;
  localparam int DIS  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [16:0] addr, addr_h;
  logic ce_n, oe_n, ce_h, oe_h;
  logic [7:0] data, data_h;
  logic valid, drive, stby, valid_h, drive_h, stby_h;

  atd_rom u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_i(ce_n), .oe_i(oe_n),
    .data_o(data), .data_valid_o(valid), .drive_en_o(drive), .standby_o(stby)
  );

  atd_rom #(.CE_ACTIVE_HIGH(1'b1), .OE_ACTIVE_HIGH(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_h), .ce_i(ce_h), .oe_i(oe_h),
    .data_o(data_h), .data_valid_o(valid_h), .drive_en_o(drive_h), .standby_o(stby_h)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic int exp_byte(input int a);
    return ((a * 29 + (a >> 8) + (a >> 16) * 90) ^ 165) & 255;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // One read at address a; prev_ok tells whether a word was valid before.
  task automatic read_at(input int a, input bit prev_ok, input int prev);
    addr = 17'(a);
    for (int k = 1; k <= ACC + 1; k++) begin
      step(1);
      if (k <= HOLD && prev_ok) begin
        chk("R6", "hold valid", int'(valid), 1);
        chk("R6", "hold data", int'(data), exp_byte(prev));
      end else if (k == ACC + 1) begin
        chk("R3", "ready valid", int'(valid), 1);
        chk("R1", "word", int'(data), exp_byte(a));
        chk("R10", "drive", int'(drive), 1);
      end else begin
        chk("R3", "pending valid", int'(valid), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cur;
    addr = 17'h00123; ce_n = 1'b0; oe_n = 1'b0;
    addr_h = '0; ce_h = 1'b0; oe_h = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(1);
    chk("R2", "valid after reset", int'(valid), 0);
    chk("R10", "drive after reset", int'(drive), 0);
    chk("R9", "standby with select on", int'(stby), 0);
    step(30);
    chk("R2", "valid with no transition", int'(valid), 0);

    // Sweep: walking ones, scattered addresses, extremes.
    cur = 'h123;
    read_at(1, 1'b0, cur);
    cur = 1;
    for (int b = 1; b < 17; b++) begin
      read_at(1 << b, 1'b1, cur);
      cur = 1 << b;
    end
    for (int i = 0; i < 40; i++) begin
      read_at((i * 4099 + 77) & 'h1FFFF, 1'b1, cur);
      cur = (i * 4099 + 77) & 'h1FFFF;
    end
    read_at('h1FFFF, 1'b1, cur);
    read_at(0, 1'b1, 'h1FFFF);
    cur = 0;

    // Output enable off: disable window, then re-enable without new access.
    oe_n = 1'b1;
    step(1);
    chk("R11", "valid after oe off", int'(valid), 0);
    chk("R11", "drive edge 1", int'(drive), 1);
    chk("R11", "data in window", int'(data), exp_byte(cur));
    for (int k = 2; k <= DIS; k++) begin
      step(1);
      chk("R11", "drive in window", int'(drive), 1);
    end
    step(1);
    chk("R11", "drive after window", int'(drive), 0);
    chk("R10", "data undriven", int'(data), 0);
    chk("R9", "standby with oe off", int'(stby), 0);
    step(10);
    chk("R5", "valid with oe off", int'(valid), 0);
    oe_n = 1'b0;
    for (int k = 1; k <= OEA; k++) begin
      step(1);
      chk("R5", "oe access pending", int'(valid), 0);
    end
    step(1);
    chk("R5", "oe re-enable valid", int'(valid), 1);
    chk("R5", "oe re-enable data", int'(data), exp_byte(cur));

    // Select off: standby regardless of output enable.
    ce_n = 1'b1;
    step(1);
    chk("R8", "standby", int'(stby), 1);
    chk("R8", "valid in standby", int'(valid), 0);
    step(DIS);
    chk("R8", "drive in standby", int'(drive), 0);
    oe_n = 1'b1; step(3);
    oe_n = 1'b0; step(3);
    chk("R8", "standby oe toggled", int'(stby), 1);
    chk("R8", "drive oe toggled", int'(drive), 0);
    chk("R8", "data oe toggled", int'(data), 0);

    // Select back on, same address: a full access.
    ce_n = 1'b0;
    for (int k = 1; k <= ACC; k++) begin
      step(1);
      chk("R4", "select access pending", int'(valid), 0);
    end
    step(1);
    chk("R4", "select access valid", int'(valid), 1);
    chk("R4", "select access data", int'(data), exp_byte(cur));
    chk("R4", "standby cleared", int'(stby), 0);

    // Restart mid-access.
    addr = 17'h0ABCD;
    step(5);
    chk("R7", "first access pending", int'(valid), 0);
    addr = 17'h15555;
    step(ACC);
    chk("R7", "restarted pending", int'(valid), 0);
    step(1);
    chk("R7", "restarted valid", int'(valid), 1);
    chk("R7", "restarted data", int'(data), exp_byte('h15555));

    // Active-high build.
    chk("R12", "high build standby", int'(stby_h), 1);
    chk("R12", "high build drive", int'(drive_h), 0);
    ce_h = 1'b1; oe_h = 1'b1;
    step(1);
    chk("R12", "high build operating", int'(stby_h), 0);
    addr_h = 17'h00F0F;
    step(ACC);
    chk("R12", "high build pending", int'(valid_h), 0);
    step(1);
    chk("R12", "high build valid", int'(valid_h), 1);
    chk("R12", "high build data", int'(data_h), exp_byte('h00F0F));
    ce_h = 1'b0;
    step(1);
    chk("R12", "high build standby again", int'(stby_h), 1);
    chk("R12", "high build valid off", int'(valid_h), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule